// File: doc/BRIEF.md
# Dual-Channel Converter Register Update Controller

This block holds the digital register path of a two-channel digital-to-analog converter. Each channel keeps two levels of storage: a staging register that takes writes from a serial front end, and an output register that drives the converter. An active-low load strobe moves pending staging data into the output registers of both channels at once. An active-low clear input forces a software-chosen clear code into every register. A power-on select pin picks whether the output registers start at zero or at midscale.

The front end hands over decoded writes: a channel number, a 16-bit left-aligned data field and an update request flag. The update request copies the value straight through to the output register. The strobe and clear pins are asynchronous. Each passes through a synchronizer before a three-state controller acts on it. The states are POR_HOLD (reset value still shown, no write seen yet), ACTIVE (normal operation) and CLR_HOLD (clear input held low). The transitions are: POR_HOLD to ACTIVE on the first write; POR_HOLD or ACTIVE to CLR_HOLD when the synchronized clear goes low, which fires the clear load once; CLR_HOLD to ACTIVE when the synchronized clear returns high.

Top module: `dac2_update_ctrl`

## Requirements
- R1: While `rst_n` is low, both output registers load 0x0000 if `por_mid` is 0 and 0x8000 if it is 1. They keep that value, through load strobes, until a write or a clear changes them.
- R2: A write with `wr_update` = 0 goes to the selected channel's staging register (`wr_chan` 0 = A, 1 = B) and marks it pending. It leaves both outputs unchanged.
- R3: `ldac_n` passes through a two-flop synchronizer. While the synchronized value is low, each pending channel copies its staging register to its output register and clears its pending mark. The output changes on the third rising clock edge after `ldac_n` falls.
- R4: With `ldac_n` held low, a write captured on one edge reaches the output on the following edge.
- R5: A write with `wr_update` = 1 loads the selected channel's output register on the capture edge. The other channel is not changed.
- R6: A channel with no pending data is not reloaded by the strobe. A clear removes every pending mark.
- R7: `clr_n` passes through a two-flop synchronizer. On its synchronized falling edge, which is the third rising edge after `clr_n` falls, the staging and output registers of both channels load the clear code. Holding `clr_n` low does not repeat the load.
- R8: The clear code is chosen by a 2-bit setting written with `clr_cfg_we`: 0 = zero, 1 = midscale 0x8000, 2 = full scale (every bit of the data field set), 3 = zero. After reset the setting is 0. Writing the setting alone does not change the outputs.
- R9: While the synchronized clear is low, strobes and update requests have no effect on the outputs. Writes still reach the staging registers and stay pending for a strobe after release.
- R10: Bits below the `DATA_W`-bit field are forced to zero in written data and in the full-scale code. For example, at `DATA_W` = 12, 0x1234 becomes 0x1230 and full scale is 0xFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_mid | input | 1 | Power-on value select: 0 zero, 1 midscale |
| wr_valid | input | 1 | Decoded write present this cycle |
| wr_chan | input | 1 | Target channel: 0 = A, 1 = B |
| wr_data | input | 16 | Left-aligned data field |
| wr_update | input | 1 | Copy the write straight to the output register |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| clr_n | input | 1 | Asynchronous active-low clear |
| clr_cfg_we | input | 1 | Write strobe for the clear-code setting |
| clr_cfg | input | 2 | Clear-code setting value |
| dac_a | output | 16 | Channel A output register |
| dac_b | output | 16 | Channel B output register |

## Verification
A stale or wrongly set pending mark shows up on the first strobe afterwards: an output moves when it should hold, or holds when it should move, three edges after `ldac_n` falls. A controller stuck in the wrong state shows within one strobe. If it wrongly sits in CLR_HOLD, strobes never move data. If it fails to enter CLR_HOLD, the clear load repeats, or strobes pass while the clear input is low. A wrong clear-code register or mask appears directly on both outputs three edges after the clear input falls. A second instance at a narrower data width exposes masking errors on every write.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

    localparam int FIELD_W  = 16;
    localparam int NCH      = 2;
    localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    localparam logic [FIELD_W-1:0] MID_CODE = {1'b1, {(FIELD_W-1){1'b0}}};

    typedef enum logic [1:0] {
        ST_POR_HOLD = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_CLR_HOLD = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_MID  = 2'd1,
        CC_FULL = 2'd2,
        CC_RSVD = 2'd3
    } clr_sel_e;

    // Clear value for a setting; full scale follows the data-field mask.
    function automatic logic [FIELD_W-1:0] clr_code_value(
        input clr_sel_e              sel,
        input logic [FIELD_W-1:0]    mask
    );
        logic [FIELD_W-1:0] v;
        case (sel)
            CC_MID:  v = MID_CODE;
            CC_FULL: v = mask;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dac2_sync.sv
module dac2_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Resets to the inactive (high) level of the active-low pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dac2_ctl_fsm.sv
module dac2_ctl_fsm
    import dac2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid_i,
    input  logic       clr_lvl_i,
    input  logic       ldac_lvl_i,
    output ctl_state_e st_o,
    output logic       clr_fire_o,
    output logic       xfer_en_o,
    output logic       upd_en_o
);

    ctl_state_e st_q;
    ctl_state_e st_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_POR_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state. Entering CLR_HOLD is the detected falling edge of clear.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POR_HOLD: begin
                if (!clr_lvl_i) begin
                    st_d = ST_CLR_HOLD;
                end else if (wr_valid_i) begin
                    st_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (!clr_lvl_i) begin
                    st_d = ST_CLR_HOLD;
                end
            end
            ST_CLR_HOLD: begin
                if (clr_lvl_i) begin
                    st_d = ST_ACTIVE;
                end
            end
            default: st_d = ST_POR_HOLD;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        clr_fire_o = 1'b0;
        xfer_en_o  = 1'b0;
        upd_en_o   = 1'b0;
        unique case (st_q)
            ST_POR_HOLD, ST_ACTIVE: begin
                clr_fire_o = !clr_lvl_i;
                upd_en_o   = clr_lvl_i;
                xfer_en_o  = clr_lvl_i && !ldac_lvl_i;
            end
            ST_CLR_HOLD: begin
                clr_fire_o = 1'b0;
                upd_en_o   = 1'b0;
                xfer_en_o  = 1'b0;
            end
            default: begin
                clr_fire_o = 1'b0;
            end
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/dac2_chan.sv
module dac2_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] por_code_i,
    input  logic         clr_fire_i,
    input  logic [W-1:0] clr_code_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         upd_now_i,
    input  logic         xfer_en_i,
    output logic [W-1:0] dac_o,
    output logic         pend_o
);

    logic [W-1:0] stage_q;
    logic [W-1:0] out_q;
    logic         pend_q;

    // Clear wins over a write; a write in a cycle defers any transfer by one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= por_code_i;
            out_q   <= por_code_i;
            pend_q  <= 1'b0;
        end else if (clr_fire_i) begin
            stage_q <= clr_code_i;
            out_q   <= clr_code_i;
            pend_q  <= 1'b0;
        end else if (wr_en_i) begin
            stage_q <= wr_data_i;
            if (upd_now_i) begin
                out_q  <= wr_data_i;
                pend_q <= 1'b0;
            end else begin
                pend_q <= 1'b1;
            end
        end else if (xfer_en_i && pend_q) begin
            out_q  <= stage_q;
            pend_q <= 1'b0;
        end
    end

    assign dac_o  = out_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/dac2_update_ctrl.sv
module dac2_update_ctrl
    import dac2_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_mid,
    input  logic        wr_valid,
    input  logic        wr_chan,
    input  logic [15:0] wr_data,
    input  logic        wr_update,
    input  logic        ldac_n,
    input  logic        clr_n,
    input  logic        clr_cfg_we,
    input  logic [1:0]  clr_cfg,
    output logic [15:0] dac_a,
    output logic [15:0] dac_b
);

    localparam int LSB_PAD = FIELD_W - DATA_W;
    localparam logic [FIELD_W-1:0] FIELD_MASK = FIELD_W'({FIELD_W{1'b1}} << LSB_PAD);

    logic               ldac_lvl;
    logic               clr_lvl;
    ctl_state_e         ctl_st;
    logic               clr_fire;
    logic               xfer_en;
    logic               upd_en;
    clr_sel_e           clr_sel_q;
    logic [FIELD_W-1:0] clr_val;
    logic [FIELD_W-1:0] por_val;
    logic [FIELD_W-1:0] wr_masked;
    logic [NCH-1:0]     pend;
    logic [FIELD_W-1:0] dac_q [NCH];

    dac2_sync #(.STAGES(SYNC_STAGES)) u_sync_ldac (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ldac_n),
        .q_o   (ldac_lvl)
    );

    dac2_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (clr_n),
        .q_o   (clr_lvl)
    );

    dac2_ctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .clr_lvl_i  (clr_lvl),
        .ldac_lvl_i (ldac_lvl),
        .st_o       (ctl_st),
        .clr_fire_o (clr_fire),
        .xfer_en_o  (xfer_en),
        .upd_en_o   (upd_en)
    );

    // Clear-code setting, zero after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_sel_q <= CC_ZERO;
        end else if (clr_cfg_we) begin
            clr_sel_q <= clr_sel_e'(clr_cfg);
        end
    end

    assign clr_val   = clr_code_value(clr_sel_q, FIELD_MASK);
    assign por_val   = por_mid ? MID_CODE : '0;
    assign wr_masked = wr_data & FIELD_MASK;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic wr_hit;
        assign wr_hit = wr_valid && (wr_chan == CH_IDX_W'(ch));

        dac2_chan #(.W(FIELD_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .por_code_i (por_val),
            .clr_fire_i (clr_fire),
            .clr_code_i (clr_val),
            .wr_en_i    (wr_hit),
            .wr_data_i  (wr_masked),
            .upd_now_i  (wr_update && upd_en),
            .xfer_en_i  (xfer_en),
            .dac_o      (dac_q[ch]),
            .pend_o     (pend[ch])
        );
    end

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];

endmodule

// File: rtl/dac2_update_ctrl_chk.sv
module dac2_update_ctrl_chk
    import dac2_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic               wr_update,
    input logic [15:0]        dac_a,
    input logic [15:0]        dac_b,
    input ctl_state_e         st,
    input logic               clr_fire,
    input logic               ldac_lvl,
    input logic [FIELD_W-1:0] clr_val,
    input logic [NCH-1:0]     pend
);

    // R1
    por_hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR_HOLD) |-> ((dac_a == dac_b) && ((dac_a == 16'h0000) || (dac_a == 16'h8000))));

    // R2
    no_cause_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_fire && ldac_lvl && !(wr_valid && wr_update)) |=> ($stable(dac_a) && $stable(dac_b)));

    // R6
    clr_drops_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (pend == '0));

    // R7
    clr_loads_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> ((dac_a == $past(clr_val)) && (dac_b == $past(clr_val))));

    // R9
    clr_hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLR_HOLD) |=> ($stable(dac_a) && $stable(dac_b)));

endmodule

bind dac2_update_ctrl dac2_update_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_update (wr_update),
    .dac_a     (dac_a),
    .dac_b     (dac_b),
    .st        (ctl_st),
    .clr_fire  (clr_fire),
    .ldac_lvl  (ldac_lvl),
    .clr_val   (clr_val),
    .pend      (pend)
);

// File: tb/dac2_update_ctrl_bench.sv
module dac2_update_ctrl_bench;

    localparam int CLK_P = 10;

    localparam int OP_WR0  = 1;
    localparam int OP_WR1  = 2;
    localparam int OP_WRU0 = 3;
    localparam int OP_WRU1 = 4;
    localparam int OP_LDAC = 5;
    localparam int OP_CLR  = 6;
    localparam int OP_CFG  = 7;

    localparam int N_VEC = 17;
    // {op, argument, expected A, expected B}
    localparam logic [51:0] VEC [N_VEC] = '{
        {4'd1, 16'h1234, 16'h0000, 16'h0000},
        {4'd2, 16'hABCD, 16'h0000, 16'h0000},
        {4'd5, 16'h0000, 16'h1234, 16'hABCD},
        {4'd5, 16'h0000, 16'h1234, 16'hABCD},
        {4'd3, 16'h5555, 16'h5555, 16'hABCD},
        {4'd4, 16'h0F0F, 16'h5555, 16'h0F0F},
        {4'd7, 16'h0001, 16'h5555, 16'h0F0F},
        {4'd6, 16'h0000, 16'h8000, 16'h8000},
        {4'd5, 16'h0000, 16'h8000, 16'h8000},
        {4'd1, 16'h7777, 16'h8000, 16'h8000},
        {4'd7, 16'h0002, 16'h8000, 16'h8000},
        {4'd6, 16'h0000, 16'hFFFF, 16'hFFFF},
        {4'd5, 16'h0000, 16'hFFFF, 16'hFFFF},
        {4'd7, 16'h0003, 16'hFFFF, 16'hFFFF},
        {4'd6, 16'h0000, 16'h0000, 16'h0000},
        {4'd2, 16'h2468, 16'h0000, 16'h0000},
        {4'd5, 16'h0000, 16'h0000, 16'h2468}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_mid = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_chan = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_update = 1'b0;
    logic        ldac_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        clr_cfg_we = 1'b0;
    logic [1:0]  clr_cfg = '0;
    logic [15:0] dac_a, dac_b, d12_a, d12_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dac2_update_ctrl u_dac2_update_ctrl (
        .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .wr_valid(wr_valid),
        .wr_chan(wr_chan), .wr_data(wr_data), .wr_update(wr_update),
        .ldac_n(ldac_n), .clr_n(clr_n), .clr_cfg_we(clr_cfg_we),
        .clr_cfg(clr_cfg), .dac_a(dac_a), .dac_b(dac_b)
    );

    // Same stimulus at a 12-bit field for R10.
    dac2_update_ctrl #(.DATA_W(12)) u_dac2_update_ctrl_w12 (
        .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .wr_valid(wr_valid),
        .wr_chan(wr_chan), .wr_data(wr_data), .wr_update(wr_update),
        .ldac_n(ldac_n), .clr_n(clr_n), .clr_cfg_we(clr_cfg_we),
        .clr_cfg(clr_cfg), .dac_a(d12_a), .dac_b(d12_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [15:0] ea, input logic [15:0] eb);
        check({req, " A"}, dac_a, ea);
        check({req, " B"}, dac_b, eb);
        check("R10 A12", d12_a, ea & 16'hFFF0);
        check("R10 B12", d12_b, eb & 16'hFFF0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic mid);
        @(negedge clk);
        rst_n   = 1'b0;
        por_mid = mid;
        settle(3);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic do_write(input logic ch, input logic [15:0] d, input logic upd);
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_chan   = ch;
        wr_data   = d;
        wr_update = upd;
        @(negedge clk);
        wr_valid  = 1'b0;
        wr_update = 1'b0;
    endtask

    task automatic pulse_ldac();
        @(negedge clk);
        ldac_n = 1'b0;
        settle(2);
        ldac_n = 1'b1;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_n = 1'b0;
        settle(5);
        clr_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [1:0] v);
        @(negedge clk);
        clr_cfg_we = 1'b1;
        clr_cfg    = v;
        @(negedge clk);
        clr_cfg_we = 1'b0;
    endtask

    function automatic string tag_of(input int op);
        case (op)
            OP_WR0, OP_WR1:   return "R2";
            OP_WRU0, OP_WRU1: return "R5";
            OP_LDAC:          return "R3";
            OP_CLR:           return "R7";
            default:          return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 midscale power-on, held through a strobe with nothing pending
        do_reset(1'b1);
        check_all("R1 mid", 16'h8000, 16'h8000);
        pulse_ldac();
        settle(4);
        check_all("R1 hold", 16'h8000, 16'h8000);

        // R1 zero power-on
        do_reset(1'b0);
        check_all("R1 zero", 16'h0000, 16'h0000);
        settle(6);
        check_all("R1 idle", 16'h0000, 16'h0000);

        for (int i = 0; i < N_VEC; i++) begin
            int          op;
            logic [15:0] arg;
            op  = int'(VEC[i][51:48]);
            arg = VEC[i][47:32];
            case (op)
                OP_WR0:  do_write(1'b0, arg, 1'b0);
                OP_WR1:  do_write(1'b1, arg, 1'b0);
                OP_WRU0: do_write(1'b0, arg, 1'b1);
                OP_WRU1: do_write(1'b1, arg, 1'b1);
                OP_LDAC: pulse_ldac();
                OP_CLR:  pulse_clr();
                default: set_cfg(arg[1:0]);
            endcase
            settle(4);
            check_all(tag_of(op), VEC[i][31:16], VEC[i][15:0]);
        end

        // R9: strobe and update request blocked while clear held low
        set_cfg(2'd0);
        @(negedge clk);
        clr_n = 1'b0;
        settle(6);
        check_all("R7 clr", 16'h0000, 16'h0000);
        do_write(1'b0, 16'h1111, 1'b1);
        pulse_ldac();
        settle(4);
        check_all("R9 blocked", 16'h0000, 16'h0000);
        clr_n = 1'b1;
        settle(4);
        check_all("R9 release", 16'h0000, 16'h0000);
        pulse_ldac();
        settle(4);
        check_all("R9 pending", 16'h1111, 16'h0000);

        // R3 strobe latency: output moves on the third edge
        do_write(1'b1, 16'h4242, 1'b0);
        ldac_n = 1'b0;
        settle(2);
        check_all("R3 early", 16'h1111, 16'h0000);
        settle(1);
        check_all("R3 edge3", 16'h1111, 16'h4242);
        ldac_n = 1'b1;
        settle(4);

        // R4 strobe tied low: one edge from capture to output
        ldac_n = 1'b0;
        settle(4);
        do_write(1'b0, 16'h0A0A, 1'b0);
        check_all("R4 capture", 16'h1111, 16'h4242);
        settle(1);
        check_all("R4 next", 16'h0A0A, 16'h4242);
        ldac_n = 1'b1;
        settle(4);

        // R6: pending write discarded by a clear, strobe restores nothing
        do_write(1'b1, 16'h9999, 1'b0);
        pulse_clr();
        settle(4);
        pulse_ldac();
        settle(4);
        check_all("R6 discard", 16'h0000, 16'h0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule